// File: doc/BRIEF.md
# STS-12 Receive Descrambler with Line AIS Override

This block sits on the byte-wide receive path of an STS-12 link, after the framer. It removes the frame-synchronous scrambling that the far end applied, using the generator 1 + x^6 + x^7 (a 7-bit register restarted at a fixed point in every frame). The row-1 framing, trace and growth bytes at the head of each frame were never scrambled, so they leave the block untouched. A configuration pin turns descrambling off for links that carry plain data.

After descrambling, the block can overwrite every byte with 0xFF to send line AIS downstream. This happens when software forces it, or when the framer reports out-of-frame and the matching enable is set. The override acts only on this block's output, so overhead taps and parity checks placed upstream still see the real stream.

Bytes flow through a valid/ready interface on both sides, with one output register. A byte is taken when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output byte and its frame mark stay frozen and no new input is taken. A cycle with no transfer does not move the frame position or the scrambler sequence.

Top module: `sts_rx_descrambler`

## Requirements
- R1: A byte taken on a clock edge appears on `out_data` with `out_valid` high directly after that same edge. `in_ready` is high after reset.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_fsync` hold their values and `in_ready` is low.
- R3: `in_fsync` marks frame offset 0, the first framing byte. Offsets 0 to 35 (3 x 12 bytes: framing, trace and growth) are output equal to the input. `out_fsync` repeats `in_fsync` with the byte.
- R4: From offset 36, each byte is XORed with the next 8 bits of a sequence. The sequence comes from a 7-bit register loaded with all ones at offset 36. Each step outputs the register's top bit, shifts left and feeds in top XOR next bit (1 + x^6 + x^7). The first bit goes to data bit 7. With zero input, the first two bytes after the overhead are 0xFE and 0x04.
- R5: Only bytes that are taken advance the frame position and the sequence. Stalls from either side do not.
- R6: An `in_fsync` byte arriving in the middle of a frame restarts the frame position at offset 0. The sequence restarts at offset 36 of the new frame.
- R7: With `cfg_bypass` high, output bytes equal input bytes. The sequence keeps its position, so descrambling resumes in step once `cfg_bypass` is cleared.
- R8: With `cfg_ais_force` high, every output byte is 0xFF, whatever the input.
- R9: With `cfg_ais_on_oof` high and `oof` high, every output byte is 0xFF. `oof` has no effect while `cfg_ais_on_oof` is low.
- R10: AIS is decided for each byte as it is taken. While AIS is active the sequence keeps advancing, so the first byte after AIS ends is descrambled at the correct position.
- R11: After reset `out_valid` is low. Bytes before the first `in_fsync` are descrambled as if they followed the frame's overhead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Scrambled receive byte |
| in_fsync | input | 1 | Input byte is frame offset 0 |
| oof | input | 1 | Framer out-of-frame indication |
| cfg_bypass | input | 1 | Pass data without descrambling |
| cfg_ais_force | input | 1 | Force all-ones output |
| cfg_ais_on_oof | input | 1 | Enable all-ones output while out-of-frame |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Descrambled or AIS byte |
| out_fsync | output | 1 | Output byte is frame offset 0 |

## Verification
Every result is due one clock edge after the edge that takes its byte, because the output register is the only register on the path. The bench drives inputs on the falling edge and samples the outputs on the next falling edge. At that point the byte is already registered and no later byte can have replaced it. In stall scenarios the bench samples at each falling edge while `out_ready` is low, to show the frozen output. It then samples one falling edge after releasing `out_ready`, when the held input byte has been taken. The bench tracks the expected sequence index only from the bytes it knows were taken.

// File: rtl/stsd_pkg.sv
package stsd_pkg;

  localparam int BYTE_W = 8;
  localparam int LFSR_W = 7;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LFSR_W-1:0] lfsr_t;

  // Sequence bits for one byte, first bit in bit 7.
  function automatic byte_t seq_byte(input lfsr_t st);
    lfsr_t s;
    byte_t b;
    s = st;
    b = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      b[BYTE_W-1-i] = s[LFSR_W-1];
      s = {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    end
    return b;
  endfunction

  // Register contents after eight steps.
  function automatic lfsr_t seq_next(input lfsr_t st);
    lfsr_t s;
    s = st;
    for (int i = 0; i < BYTE_W; i++) begin
      s = {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    end
    return s;
  endfunction

endpackage

// File: rtl/stsd_rowpos.sv
// Tracks where the current byte sits relative to the unscrambled row-1 head.
module stsd_rowpos #(
  parameter int N_STS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic fsync,
  output logic in_head
);
  localparam int PASS  = 3 * N_STS;
  localparam int CNT_W = $clog2(PASS + 1);

  logic [CNT_W-1:0] cnt;

  assign in_head = fsync || (cnt < CNT_W'(PASS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= CNT_W'(PASS);
    end else if (take) begin
      if (fsync)
        cnt <= CNT_W'(1);
      else if (cnt < CNT_W'(PASS))
        cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/stsd_lfsr.sv
// Frame-synchronous sequence generator, eight steps per payload byte.
module stsd_lfsr
  import stsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  restart,
  input  logic  in_head,
  output byte_t mask
);
  lfsr_t st;

  assign mask = seq_byte(st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '1;
    end else if (take) begin
      if (restart)
        st <= '1;
      else if (!in_head)
        st <= seq_next(st);
    end
  end
endmodule

// File: rtl/stsd_outstage.sv
// Selects descrambled, raw or all-ones data and holds it in a one-deep stage.
module stsd_outstage
  import stsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  byte_t in_data,
  input  logic  in_fsync,
  input  byte_t mask,
  input  logic  in_head,
  input  logic  bypass,
  input  logic  ais,
  output logic  out_valid,
  input  logic  out_ready,
  output byte_t out_data,
  output logic  out_fsync
);
  byte_t next_data;
  logic  take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    if (ais)
      next_data = '1;
    else if (bypass || in_head)
      next_data = in_data;
    else
      next_data = in_data ^ mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_fsync <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= next_data;
      out_fsync <= in_fsync;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sts_rx_descrambler.sv
module sts_rx_descrambler
  import stsd_pkg::*;
#(
  parameter int N_STS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_fsync,
  input  logic       oof,
  input  logic       cfg_bypass,
  input  logic       cfg_ais_force,
  input  logic       cfg_ais_on_oof,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_fsync
);
  logic  take;
  logic  in_head;
  logic  ais;
  byte_t mask;

  assign take = in_valid && in_ready;
  assign ais  = cfg_ais_force || (cfg_ais_on_oof && oof);

  stsd_rowpos #(.N_STS(N_STS)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .fsync   (in_fsync),
    .in_head (in_head)
  );

  stsd_lfsr u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .restart (in_fsync),
    .in_head (in_head),
    .mask    (mask)
  );

  stsd_outstage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_fsync  (in_fsync),
    .mask      (mask),
    .in_head   (in_head),
    .bypass    (cfg_bypass),
    .ais       (ais),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_fsync (out_fsync)
  );
endmodule

// File: rtl/sts_rx_descrambler_chk.sv
module sts_rx_descrambler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_fsync,
  input logic       oof,
  input logic       cfg_bypass,
  input logic       cfg_ais_force,
  input logic       cfg_ais_on_oof,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_fsync
);
  logic acc;
  logic ais_req;
  assign acc     = in_valid && in_ready;
  assign ais_req = cfg_ais_force || (cfg_ais_on_oof && oof);

  a_r1_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fsync)));

  a_r2_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r3_head_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_fsync && !ais_req) |=> (out_data == $past(in_data) && out_fsync));

  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg_bypass && !ais_req) |=> out_data == $past(in_data));

  a_r8_force: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg_ais_force) |=> out_data == 8'hFF);

  a_r9_oof: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg_ais_on_oof && oof) |=> out_data == 8'hFF);
endmodule

bind sts_rx_descrambler sts_rx_descrambler_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_data        (in_data),
  .in_fsync       (in_fsync),
  .oof            (oof),
  .cfg_bypass     (cfg_bypass),
  .cfg_ais_force  (cfg_ais_force),
  .cfg_ais_on_oof (cfg_ais_on_oof),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_data       (out_data),
  .out_fsync      (out_fsync)
);

// File: tb/sim_sts_rx_descrambler.sv
module sim_sts_rx_descrambler;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, in_valid, in_ready, in_fsync, oof;
  logic       cfg_bypass, cfg_ais_force, cfg_ais_on_oof;
  logic       out_valid, out_ready, out_fsync;
  logic [7:0] in_data, out_data;

  int  n_cmp = 0;
  int  n_bad = 0;
  int  sidx  = 0;
  bit  done  = 0;

  sts_rx_descrambler u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_fsync(in_fsync), .oof(oof),
    .cfg_bypass(cfg_bypass), .cfg_ais_force(cfg_ais_force),
    .cfg_ais_on_oof(cfg_ais_on_oof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_fsync(out_fsync)
  );

  // Byte n of the sequence: 7-bit register from all ones, 1 + x^6 + x^7.
  function automatic logic [7:0] seqb(input int n);
    logic [6:0] s;
    logic [7:0] b;
    s = 7'h7F;
    b = 8'h00;
    for (int k = 0; k <= n; k++) begin
      for (int i = 0; i < 8; i++) begin
        b[7-i] = s[6];
        s = {s[5:0], s[6] ^ s[5]};
      end
    end
    return b;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, input logic fs,
                      output logic [7:0] got, output logic vld, output logic fso);
    @(negedge clk);
    in_data  = d;
    in_fsync = fs;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_fsync = 1'b0;
    got = out_data;
    vld = out_valid;
    fso = out_fsync;
  endtask

  task automatic send_head(input string tag);
    logic [7:0] g, d;
    logic v, f;
    int bad;
    bad = 0;
    for (int i = 0; i < 36; i++) begin
      d = (i < 12) ? 8'hF6 : (i < 24) ? 8'h28 : 8'(i);
      xfer(d, i == 0, g, v, f);
      if (i == 0) chk({tag, " R3 out_fsync"}, {7'b0, f}, 8'h01);
      if (g !== d) bad++;
    end
    chk({tag, " R3 head bytes unchanged (bad count)"}, 8'(bad), 8'h00);
    sidx = 0;
  endtask

  task automatic send_pay(input string tag, input logic [7:0] d);
    logic [7:0] g;
    logic v, f;
    xfer(d, 1'b0, g, v, f);
    chk(tag, g, d ^ seqb(sidx));
    sidx++;
  endtask

  task automatic t_reset();
    chk("R11 out_valid after reset", {7'b0, out_valid}, 8'h00);
    chk("R1 in_ready after reset", {7'b0, in_ready}, 8'h01);
  endtask

  task automatic t_frame();
    logic [7:0] g;
    logic v, f;
    send_head("frame");
    xfer(8'h00, 1'b0, g, v, f);
    chk("R4 first sequence byte", g, 8'hFE);
    chk("R1 out_valid after take", {7'b0, v}, 8'h01);
    xfer(8'h00, 1'b0, g, v, f);
    chk("R4 second sequence byte", g, 8'h04);
    sidx = 2;
    for (int i = 0; i < 6; i++) send_pay("R4 payload", 8'(8'h3C + 37 * i));
  endtask

  task automatic t_stall();
    logic [7:0] a, b, held;
    a = 8'hA5;
    b = 8'h5A;
    @(negedge clk);
    out_ready = 1'b0;
    in_data   = a;
    in_valid  = 1'b1;
    @(negedge clk);
    held = out_data;
    chk("R1 stalled byte registered", held, a ^ seqb(sidx));
    in_data = b;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 data held", out_data, held);
      chk("R2 in_ready low", {7'b0, in_ready}, 8'h00);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 next byte after stall", out_data, b ^ seqb(sidx + 1));
    sidx += 2;
  endtask

  task automatic t_bypass();
    logic [7:0] g;
    logic v, f;
    cfg_bypass = 1'b1;
    for (int i = 0; i < 3; i++) begin
      xfer(8'(8'h11 * (i + 1)), 1'b0, g, v, f);
      chk("R7 bypass raw", g, 8'(8'h11 * (i + 1)));
      sidx++;
    end
    cfg_bypass = 1'b0;
    send_pay("R7 resume in step", 8'h77);
  endtask

  task automatic t_force();
    logic [7:0] g;
    logic v, f;
    cfg_ais_force = 1'b1;
    for (int i = 0; i < 4; i++) begin
      xfer(8'(i * 19), 1'b0, g, v, f);
      chk("R8 forced AIS", g, 8'hFF);
      sidx++;
    end
    cfg_ais_force = 1'b0;
    send_pay("R10 resume after AIS", 8'h00);
  endtask

  task automatic t_oof();
    oof = 1'b1;
    send_pay("R9 oof without enable", 8'h42);
    cfg_ais_on_oof = 1'b1;
    begin
      logic [7:0] g;
      logic v, f;
      xfer(8'h42, 1'b0, g, v, f);
      chk("R9 oof with enable", g, 8'hFF);
      sidx++;
    end
    oof = 1'b0;
    send_pay("R9 enable without oof", 8'h42);
    cfg_ais_on_oof = 1'b0;
  endtask

  task automatic t_resync();
    logic [7:0] g;
    logic v, f;
    send_head("resync");
    xfer(8'h81, 1'b0, g, v, f);
    chk("R6 restart after mid-frame fsync", g, 8'h81 ^ 8'hFE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_fsync = 1'b0;
    oof = 1'b0; cfg_bypass = 1'b0; cfg_ais_force = 1'b0; cfg_ais_on_oof = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame();
    t_stall();
    t_bypass();
    t_force();
    t_oof();
    t_resync();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule